// File: doc/BRIEF.md
# Window-Threshold Channel Alarm Monitor

This block watches a stream of conversion results from a multi-channel converter. Each result carries a slot index. The block compares the result with a lower and an upper threshold that are set for that slot. A result that falls strictly outside the window raises the slot's alarm-status bit. The offending value is copied into the slot's fault snapshot register. Separately, every accepted result is written to the slot's current-result register.

Results arrive on a valid/ready input. A result is consumed on a rising clock edge where `in_valid` and `in_ready` are both high. Its effects are visible in the outputs after that edge. `in_ready` falls while `freeze` is asserted. A producer must then hold its result, with `in_valid`, `in_chan` and `in_data` stable, until `in_ready` returns.

The comparison is either unsigned or two's-complement, as selected by `bipolar`. The two extreme threshold pairs make the window cover every code, so a slot set up that way can never alarm. Each slot's alarm is cleared by its own one-cycle strobe. The strobe leaves the snapshot register untouched.

Top module: `wnd_alarm_mon`

## Requirements
- R1: After reset, every alarm-status bit, fault snapshot and current result is zero, and `in_ready` is high while `freeze` is low.
- R2: A result is accepted only on a rising edge with `in_valid` and `in_ready` both high; its effects appear on the outputs right after that edge.
- R3: With `bipolar` = 0, the result and thresholds are compared as unsigned 12-bit values; a result below the lower threshold or above the upper one raises the slot's status bit, and a result equal to either threshold does not.
- R4: With `bipolar` = 1, the same strict comparison is made on 12-bit two's-complement values (bit 11 is the sign).
- R5: A slot whose thresholds are lower 0x000 / upper 0xFFF in unsigned mode, or lower 0x800 / upper 0x7FF in signed mode, never raises its status bit, whatever result it receives.
- R6: Each accepted result replaces the current-result register of its own slot and changes no other slot's registers.
- R7: When a slot's status bit goes from 0 to 1, its fault snapshot holds exactly the result that caused the trip.
- R8: While a slot's status bit stays set, further out-of-window results do not change its fault snapshot.
- R9: A high bit in `alarm_clr` clears only that slot's status bit and leaves the slot's snapshot unchanged. If a trip on the same slot is accepted on the same edge, the status bit stays 1 and the snapshot takes the new result.
- R10: While `freeze` is high, `in_ready` is low and an offered result changes no current result, status bit or snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bipolar | input | 1 | 1: two's-complement comparison, 0: unsigned |
| thr_lo | input | NCH*DW | Lower thresholds, slot i in bits [i*DW +: DW] |
| thr_hi | input | NCH*DW | Upper thresholds, slot i in bits [i*DW +: DW] |
| freeze | input | 1 | Holds off acceptance and alarm evaluation |
| alarm_clr | input | NCH | Per-slot alarm reset strobe |
| in_valid | input | 1 | Result offered |
| in_ready | output | 1 | Result can be accepted |
| in_chan | input | CW | Slot index of the offered result |
| in_data | input | DW | Offered conversion result |
| alarm_stat | output | NCH | Per-slot alarm-status bits |
| fault_val | output | NCH*DW | Per-slot fault snapshots, slot i in [i*DW +: DW] |
| cur_val | output | NCH*DW | Per-slot current results, slot i in [i*DW +: DW] |

## Verification
The bench sweeps every 12-bit code through one slot in both formats. The thresholds are placed so that an unsigned compare used in signed mode gives wrong answers. A comparator that is off by one at the window edges, or that uses the wrong signedness, shows up as status bits that differ from the arithmetic model. Two more full sweeps use the extreme threshold pairs and catch any slot that alarms when it should stay silent. Directed sequences cover these faults:
- a snapshot overwritten by a second excursion while the alarm is set;
- a clear strobe that also wipes the snapshot or touches another slot;
- a simultaneous clear-and-trip that loses the new trip;
- a freeze that still lets results through.

// File: rtl/wam_pkg.sv
package wam_pkg;
  typedef enum logic {
    FMT_UNSIGNED = 1'b0,
    FMT_SIGNED   = 1'b1
  } wam_fmt_e;
endpackage

// File: rtl/wam_cmp.sv
module wam_cmp
  import wam_pkg::*;
#(
  parameter int DW = 12
) (
  input  wam_fmt_e        fmt,
  input  logic [DW-1:0]   data,
  input  logic [DW-1:0]   lo,
  input  logic [DW-1:0]   hi,
  output logic            outside
);
  // Extend by one bit so a single signed compare serves both formats.
  logic signed [DW:0] d_x, lo_x, hi_x;
  logic               sext;

  always_comb begin
    sext    = (fmt == FMT_SIGNED);
    d_x     = {sext & data[DW-1], data};
    lo_x    = {sext & lo[DW-1], lo};
    hi_x    = {sext & hi[DW-1], hi};
    outside = (d_x < lo_x) || (d_x > hi_x);
  end
endmodule

// File: rtl/wam_slot.sv
module wam_slot #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          trip,
  input  logic          clr,
  input  logic [DW-1:0] data,
  output logic          stat,
  output logic [DW-1:0] flt,
  output logic [DW-1:0] cur
);
  logic hit;
  logic grab;

  always_comb begin
    hit  = wr & trip;
    grab = hit & (~stat | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= 1'b0;
      flt  <= '0;
      cur  <= '0;
    end else begin
      if (wr)   cur <= data;
      if (grab) flt <= data;
      stat <= (stat & ~clr) | hit;
    end
  end

  AST_CUR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cur == $past(data))); // R6
  AST_TRIP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && trip) |=> stat); // R3
  AST_FIRST_TRIP_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && trip && !stat) |=> (flt == $past(data))); // R7
  AST_SNAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr) |=> $stable(flt)); // R8
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(wr && trip)) |=> !stat); // R9
  AST_CLR_KEEPS_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr) |=> $stable(flt)); // R9
endmodule

// File: rtl/wnd_alarm_mon.sv
module wnd_alarm_mon
  import wam_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bipolar,
  input  logic [NCH*DW-1:0] thr_lo,
  input  logic [NCH*DW-1:0] thr_hi,
  input  logic              freeze,
  input  logic [NCH-1:0]    alarm_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CW-1:0]     in_chan,
  input  logic [DW-1:0]     in_data,
  output logic [NCH-1:0]    alarm_stat,
  output logic [NCH*DW-1:0] fault_val,
  output logic [NCH*DW-1:0] cur_val
);
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  wam_fmt_e      fmt;
  logic          accept;
  logic [DW-1:0] sel_lo, sel_hi;
  logic          outside;

  always_comb begin
    fmt      = bipolar ? FMT_SIGNED : FMT_UNSIGNED;
    in_ready = ~freeze;
    accept   = in_valid & in_ready;
    sel_lo   = thr_lo[in_chan*DW +: DW];
    sel_hi   = thr_hi[in_chan*DW +: DW];
  end

  wam_cmp #(.DW(DW)) u_cmp (
    .fmt     (fmt),
    .data    (in_data),
    .lo      (sel_lo),
    .hi      (sel_hi),
    .outside (outside)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic wr_i;
    assign wr_i = accept && (in_chan == CW'(i));
    wam_slot #(.DW(DW)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_i),
      .trip  (outside),
      .clr   (alarm_clr[i]),
      .data  (in_data),
      .stat  (alarm_stat[i]),
      .flt   (fault_val[i*DW +: DW]),
      .cur   (cur_val[i*DW +: DW])
    );
  end

  AST_SIGNED_OPEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bipolar && sel_lo == SMIN && sel_hi == SMAX) |-> !outside); // R5
  AST_UNSIGNED_OPEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!bipolar && sel_lo == '0 && sel_hi == '1) |-> !outside); // R5
  AST_FROZEN_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(cur_val)); // R10
  AST_FROZEN_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(fault_val)); // R10
endmodule

// File: tb/sim_wnd_alarm_mon.sv
module sim_wnd_alarm_mon;
  localparam int NCH = 4;
  localparam int DW  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bipolar = 1'b0;
  logic [NCH*DW-1:0] thr_lo = '0;
  logic [NCH*DW-1:0] thr_hi = '1;
  logic              freeze = 1'b0;
  logic [NCH-1:0]    alarm_clr = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_chan = '0;
  logic [DW-1:0]     in_data = '0;
  logic [NCH-1:0]    alarm_stat;
  logic [NCH*DW-1:0] fault_val;
  logic [NCH*DW-1:0] cur_val;

  int n_chk = 0;
  int n_bad = 0;

  logic          m_st [NCH];
  logic [DW-1:0] m_flt[NCH];
  logic [DW-1:0] m_cur[NCH];

  always #10 clk = ~clk;

  wnd_alarm_mon #(.NCH(NCH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bipolar(bipolar), .thr_lo(thr_lo),
    .thr_hi(thr_hi), .freeze(freeze), .alarm_clr(alarm_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
    .in_data(in_data), .alarm_stat(alarm_stat), .fault_val(fault_val),
    .cur_val(cur_val)
  );

  function automatic int sval(logic bip, logic [DW-1:0] v);
    if (bip && v[DW-1]) return int'(v) - (1 << DW);
    return int'(v);
  endfunction

  function automatic logic exp_out(logic bip, logic [DW-1:0] v,
                                   logic [DW-1:0] lo, logic [DW-1:0] hi);
    return (sval(bip, v) < sval(bip, lo)) || (sval(bip, v) > sval(bip, hi));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NCH; i++) begin
      chk(tag, int'(alarm_stat[i]), int'(m_st[i]));
      chk(tag, int'(fault_val[i*DW +: DW]), int'(m_flt[i]));
      chk(tag, int'(cur_val[i*DW +: DW]), int'(m_cur[i]));
    end
  endtask

  task automatic set_thr(int ch, logic [DW-1:0] lo, logic [DW-1:0] hi);
    thr_lo[ch*DW +: DW] = lo;
    thr_hi[ch*DW +: DW] = hi;
  endtask

  // Starts and ends at a falling edge.
  task automatic step(logic vld, int ch, logic [DW-1:0] v, logic [NCH-1:0] clr);
    in_valid  = vld;
    in_chan   = 2'(ch);
    in_data   = v;
    alarm_clr = clr;
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      logic acc, trip;
      acc  = vld && !freeze && (ch == i);
      trip = acc && exp_out(bipolar, v, thr_lo[i*DW +: DW], thr_hi[i*DW +: DW]);
      if (acc) m_cur[i] = v;
      if (trip && (!m_st[i] || clr[i])) m_flt[i] = v;
      m_st[i] = (m_st[i] && !clr[i]) || trip;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    alarm_clr = '0;
  endtask

  task automatic sweep(logic bip, logic [DW-1:0] lo, logic [DW-1:0] hi, string tag);
    bipolar = bip;
    set_thr(0, lo, hi);
    for (int v = 0; v < (1 << DW); v++) begin
      step(1'b1, 0, DW'(v), '0);
      check_all(tag);
      if (m_st[0]) begin
        step(1'b0, 0, '0, 4'b0001);
        check_all("R9 clear keeps snapshot");
      end
    end
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_st[i] = 1'b0; m_flt[i] = '0; m_cur[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state");
    chk("R1 ready after reset", int'(in_ready), 1);

    // R2: offered but not valid changes nothing
    step(1'b0, 1, 12'hFFF, '0);
    check_all("R2 no accept without valid");

    sweep(1'b0, 12'h100, 12'hE00, "R3 R7 unsigned window");
    sweep(1'b1, 12'hF00, 12'h0FF, "R4 R7 signed window");
    sweep(1'b0, 12'h000, 12'hFFF, "R5 unsigned open window");
    sweep(1'b1, 12'h800, 12'h7FF, "R5 signed open window");

    // R6: per-slot current results, isolation
    bipolar = 1'b0;
    for (int i = 0; i < NCH; i++) set_thr(i, 12'h000, 12'hFFF);
    for (int i = 1; i < NCH; i++) begin
      step(1'b1, i, DW'(12'h111 * i), '0);
      check_all("R6 slot isolation");
    end

    // R8: sticky snapshot on slot 2
    set_thr(2, 12'h100, 12'h200);
    step(1'b1, 2, 12'h050, '0);
    check_all("R7 first trip snapshot");
    step(1'b1, 2, 12'h300, '0);
    check_all("R8 no overwrite while set");
    step(1'b1, 2, 12'h150, '0);
    check_all("R8 in-window keeps status");

    // R9: clear one slot, another stays alarmed
    set_thr(3, 12'h100, 12'h200);
    step(1'b1, 3, 12'h7AA, '0);
    step(1'b0, 0, '0, 4'b0100);
    check_all("R9 clear only own slot");
    step(1'b1, 3, 12'hFFF, 4'b1000);
    check_all("R9 clear with trip same edge");

    // R10: freeze
    freeze = 1'b1;
    set_thr(1, 12'h100, 12'h200);
    @(negedge clk);
    chk("R10 ready low when frozen", int'(in_ready), 0);
    step(1'b1, 1, 12'hABC, '0);
    check_all("R10 frozen result dropped");
    step(1'b1, 0, 12'h001, '0);
    check_all("R10 frozen result dropped");
    freeze = 1'b0;
    @(negedge clk);
    chk("R2 ready after unfreeze", int'(in_ready), 1);
    step(1'b1, 1, 12'hABC, '0);
    check_all("R2 R7 accepted after unfreeze");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule